// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen interrupt request lines and turns them into one vectored request for a small processor core. A pending flag is latched for a source when its request line rises. The flag stays set until the core takes that source's vector. The sources are arranged in six groups of three. Each group carries a two-bit priority level, and every source in the group uses it. Level 3 is the most urgent and level 0 the least.

The resolver picks the most urgent enabled pending source. When sources tie on level, the lowest index wins. The core receives the pick on a valid/ready vector port. A transfer happens in any cycle where `vec_valid` and `vec_ready` are both high. That transfer clears the source's pending flag and records its level as in service. An in-service record lets a strictly higher level preempt it, and nothing else. A return pulse from the core retires the most urgent level in service.

Two wake outputs serve the power controller. `idle_exit` rises for any enabled pending source, whatever the global enable says. `sleep_wake` rises only for pending sources chosen by a wake mask.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset no flag is pending and no level is in service, so `vec_valid`, `idle_exit` and `sleep_wake` are all low.
- R2: A source's pending flag is set in the clock edge at which its request is sampled high after being sampled low. A request held high sets the flag once only.
- R3: Source i belongs to group i/3. Group g takes its level from `grp_prio[2g+1:2g]`, and a larger value is more urgent.
- R4: `vec_idx` names the enabled pending source of highest level. When several share that level, the lowest index is named.
- R5: While `glob_en` is low, `vec_valid` stays low and pending flags are kept. Raising `glob_en` again presents the held request.
- R6: A source whose `src_en` bit is low is never presented, and it does not drive `idle_exit`. Its flag is still kept.
- R7: A transfer takes place only when `vec_valid` and `vec_ready` are high together. Until then the offered request stays up, and no flag or in-service state changes.
- R8: A candidate is presented only when no level is in service, or when its level is strictly above the highest level in service. An equal or lower level waits.
- R9: A `reti` pulse retires the highest level in service. With nothing in service it has no effect.
- R10: `idle_exit` is high whenever some pending source is enabled by `src_en`. `glob_en` does not affect it.
- R11: `sleep_wake` is high whenever some pending source has its `wake_mask` bit set. Enables do not affect it.
- R12: If a source's vector is taken in the same cycle as a new rising edge of that source, its pending flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 18 | Interrupt request lines, edge-captured |
| src_en | input | 18 | Per-source enable |
| glob_en | input | 1 | Global vector enable |
| grp_prio | input | 12 | Six two-bit group levels, group 0 in the low bits |
| wake_mask | input | 18 | Sources allowed to raise the sleep wake |
| vec_valid | output | 1 | A vector is offered |
| vec_idx | output | 5 | Index of the offered source |
| vec_ready | input | 1 | Core takes the offered vector |
| reti | input | 1 | Core returns from the current handler |
| idle_exit | output | 1 | An enabled request is pending |
| sleep_wake | output | 1 | A wake-masked request is pending |

## Verification
Three things can land on the same clock edge: taking a vector, a new rising edge on that same source, and a return pulse. The bench steers a source low and then high again, timing it so the rise meets the cycle in which its vector is taken. It then expects the flag to survive, to stay hidden under its own in-service level, and to come back once `reti` retires that level. In a later random phase, transfers, returns, edges and enable changes all overlap. Each cycle is judged against a behavioural model, which applies the retire before it records the new level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int IRQ_N   = 18;
  parameter int IRQ_G   = 6;
  parameter int IRQ_LVW = 2;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;

  assign rise = req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      // a fresh edge wins over a clear in the same cycle
      pend  <= rise | (pend & ~clr);
    end
  end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
  parameter int N     = 18,
  parameter int G     = 6,
  parameter int LVW   = 2,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     src_en,
  input  logic             glob_en,
  input  logic [G*LVW-1:0] grp_prio,
  input  logic             top_vld,
  input  logic [LVW-1:0]   top_lvl,
  output logic             req_vld,
  output logic [IDX_W-1:0] req_idx,
  output logic [LVW-1:0]   req_lvl
);
  localparam int SPG = N / G;

  logic [N-1:0]   cand;
  logic [LVW-1:0] src_lvl [N];

  assign cand = pend & src_en & {N{glob_en}};

  for (genvar i = 0; i < N; i++) begin : g_lvl
    assign src_lvl[i] = grp_prio[(i/SPG)*LVW +: LVW];
  end

  logic found;
  always_comb begin
    found   = 1'b0;
    req_idx = '0;
    req_lvl = '0;
    // descending scan: ties resolve to the lower index
    for (int i = N-1; i >= 0; i--) begin
      if (cand[i] && (!found || src_lvl[i] >= req_lvl)) begin
        found   = 1'b1;
        req_idx = IDX_W'(i);
        req_lvl = src_lvl[i];
      end
    end
  end

  assign req_vld = found && (!top_vld || (req_lvl > top_lvl));
endmodule

// File: rtl/irq_nest.sv
module irq_nest #(
  parameter int LVW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [LVW-1:0] push_lvl,
  input  logic           pop,
  output logic           top_vld,
  output logic [LVW-1:0] top_lvl
);
  localparam int NLVL = 1 << LVW;

  logic [NLVL-1:0] act;
  logic [NLVL-1:0] pop_mask;
  logic [NLVL-1:0] push_mask;

  always_comb begin
    top_vld = 1'b0;
    top_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (act[l]) begin
        top_vld = 1'b1;
        top_lvl = LVW'(l);
      end
    end
  end

  always_comb begin
    pop_mask  = '0;
    push_mask = '0;
    if (pop && top_vld) pop_mask[top_lvl] = 1'b1;
    if (push)           push_mask[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) act <= '0;
    else        act <= (act & ~pop_mask) | push_mask;
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_pkg::*;
#(
  parameter int N     = IRQ_N,
  parameter int G     = IRQ_G,
  parameter int LVW   = IRQ_LVW,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_req,
  input  logic [N-1:0]     src_en,
  input  logic             glob_en,
  input  logic [G*LVW-1:0] grp_prio,
  input  logic [N-1:0]     wake_mask,
  output logic             vec_valid,
  output logic [IDX_W-1:0] vec_idx,
  input  logic             vec_ready,
  input  logic             reti,
  output logic             idle_exit,
  output logic             sleep_wake
);
  logic [N-1:0]   pend;
  logic [N-1:0]   clr;
  logic           take;
  logic           top_vld;
  logic [LVW-1:0] top_lvl;
  logic [LVW-1:0] win_lvl;

  assign take = vec_valid & vec_ready;

  always_comb begin
    clr = '0;
    if (take) clr[vec_idx] = 1'b1;
  end

  irq_pending #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(clr), .pend(pend)
  );

  irq_resolve #(.N(N), .G(G), .LVW(LVW), .IDX_W(IDX_W)) u_res (
    .pend(pend), .src_en(src_en), .glob_en(glob_en), .grp_prio(grp_prio),
    .top_vld(top_vld), .top_lvl(top_lvl),
    .req_vld(vec_valid), .req_idx(vec_idx), .req_lvl(win_lvl)
  );

  irq_nest #(.LVW(LVW)) u_nest (
    .clk(clk), .rst_n(rst_n), .push(take), .push_lvl(win_lvl), .pop(reti),
    .top_vld(top_vld), .top_lvl(top_lvl)
  );

  assign idle_exit  = |(pend & src_en);
  assign sleep_wake = |(pend & wake_mask);
endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk #(
  parameter int N     = 18,
  parameter int G     = 6,
  parameter int LVW   = 2,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     src_en,
  input logic             glob_en,
  input logic [G*LVW-1:0] grp_prio,
  input logic [N-1:0]     wake_mask,
  input logic             vec_valid,
  input logic [IDX_W-1:0] vec_idx,
  input logic             vec_ready,
  input logic             reti,
  input logic             idle_exit,
  input logic             sleep_wake
);
  localparam int SPG = N / G;

  function automatic int lvl_of(input logic [G*LVW-1:0] p, input logic [IDX_W-1:0] i);
    return int'(p[(int'(i)/SPG)*LVW +: LVW]);
  endfunction

  a_r5_glob_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !vec_valid);

  a_r4_idx_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (int'(vec_idx) < N) && src_en[vec_idx]);

  a_r10_idle_covers: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> idle_exit);

  a_r11_no_mask_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_mask == '0) |-> !sleep_wake);

  a_r8_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && !reti) |=>
      (!vec_valid || !$stable(grp_prio) ||
       lvl_of(grp_prio, vec_idx) > lvl_of($past(grp_prio), $past(vec_idx))));
endmodule

bind irq_group_ctrl irq_group_ctrl_chk #(.N(N), .G(G), .LVW(LVW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_en(src_en), .glob_en(glob_en),
  .grp_prio(grp_prio), .wake_mask(wake_mask), .vec_valid(vec_valid),
  .vec_idx(vec_idx), .vec_ready(vec_ready), .reti(reti),
  .idle_exit(idle_exit), .sleep_wake(sleep_wake)
);

// File: tb/sim_irq_group_ctrl.sv
module sim_irq_group_ctrl;
  localparam int TCLK = 10;
  localparam int N = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, en = '1, wmask = '0;
  logic gen = 1'b1, rdy = 1'b0, ret = 1'b0;
  logic [11:0] prio = 12'b10_01_11_00_10_01;
  logic vv, ie, sw;
  logic [4:0] vi;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  bit m_pend [N];
  bit m_prev [N];
  bit m_ins  [4];

  always #(TCLK/2) clk = ~clk;

  irq_group_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .src_en(en), .glob_en(gen),
    .grp_prio(prio), .wake_mask(wmask), .vec_valid(vv), .vec_idx(vi),
    .vec_ready(rdy), .reti(ret), .idle_exit(ie), .sleep_wake(sw)
  );

  function automatic int lv(int i);
    return int'(prio[(i/3)*2 +: 2]);
  endfunction

  function automatic int m_top();
    int t = -1;
    for (int l = 0; l < 4; l++) if (m_ins[l]) t = l;
    return t;
  endfunction

  function automatic int m_best();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && en[i] && gen && (b < 0 || lv(i) > lv(b))) b = i;
    return b;
  endfunction

  function automatic bit m_valid();
    int b = m_best();
    return (b >= 0) && (m_top() < 0 || lv(b) > m_top());
  endfunction

  function automatic bit m_idle();
    bit r = 0;
    for (int i = 0; i < N; i++) if (m_pend[i] && en[i]) r = 1;
    return r;
  endfunction

  function automatic bit m_wake();
    bit r = 0;
    for (int i = 0; i < N; i++) if (m_pend[i] && wmask[i]) r = 1;
    return r;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
    for (int l = 0; l < 4; l++) m_ins[l] = 0;
  endtask

  task automatic m_update();
    bit acc = m_valid() && rdy;
    int b = m_best();
    int t = m_top();
    if (!rst_n) begin m_reset(); return; end
    if (ret && t >= 0) m_ins[t] = 0;
    if (acc) m_ins[lv(b)] = 1;
    for (int i = 0; i < N; i++) begin
      bit rise = req[i] && !m_prev[i];
      m_pend[i] = rise || (m_pend[i] && !(acc && i == b));
      m_prev[i] = req[i];
    end
  endtask

  task automatic compare();
    chk(int'(vv), int'(m_valid()), "R8 vec_valid");
    if (m_valid()) chk(int'(vi), m_best(), "R4 vec_idx");
    chk(int'(ie), int'(m_idle()), "R10 idle_exit");
    chk(int'(sw), int'(m_wake()), "R11 sleep_wake");
  endtask

  task automatic tick();
    m_update();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic drain();
    for (int k = 0; k < 24 && m_valid(); k++) begin
      rdy = 1; tick(); rdy = 0;
      ret = 1; tick(); ret = 0;
    end
    ret = 1; tick(); ret = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    m_reset();
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    tick();
    chk(int'(vv), 0, "R1 valid after reset");
    chk(int'(ie), 0, "R1 idle after reset");
    chk(int'(sw), 0, "R1 wake after reset");

    // R2 edge capture and single trigger
    req[7] = 1; tick();
    chk(int'(vv), 1, "R2 valid on edge"); chk(int'(vi), 7, "R2 idx");
    rdy = 1; tick(); rdy = 0;
    chk(int'(vv), 0, "R7 taken clears");
    tick();
    chk(int'(vv), 0, "R2 held high no retrigger");
    ret = 1; tick(); ret = 0; req[7] = 0; tick();

    // R3/R4 ordering by group level
    req[1] = 1; req[5] = 1; req[13] = 1; req[16] = 1; tick();
    chk(int'(vi), 5, "R4 highest level lowest index");
    rdy = 1; tick(); rdy = 0;
    chk(int'(vv), 0, "R8 equal level waits");
    ret = 1; tick(); ret = 0;
    chk(int'(vi), 16, "R4 next at level 2");
    drain(); req = '0; tick();

    // R3 reprogrammed group level
    req[0] = 1; req[17] = 1; tick();
    chk(int'(vi), 17, "R3 group5 above group0");
    prio[1:0] = 2'd3; tick();
    chk(int'(vi), 0, "R3 group0 raised to 3");
    drain(); req = '0; prio = 12'b10_01_11_00_10_01; tick();

    // R4 tie inside one group
    req[10] = 1; req[9] = 1; tick();
    chk(int'(vi), 9, "R4 tie lowest index");
    drain(); req = '0; tick();

    // R5 global enable
    gen = 0; req[2] = 1; tick();
    chk(int'(vv), 0, "R5 masked"); chk(int'(ie), 1, "R5 flag kept");
    gen = 1; tick();
    chk(int'(vv), 1, "R5 released"); chk(int'(vi), 2, "R5 idx");
    drain(); req = '0; tick();

    // R6 per-source enable
    en[3] = 0; req[3] = 1; tick();
    chk(int'(vv), 0, "R6 masked source"); chk(int'(ie), 0, "R6 no idle exit");
    en[3] = 1; tick();
    chk(int'(vi), 3, "R6 flag kept");
    drain(); req = '0; tick();

    // R8 preemption
    req[6] = 1; tick(); rdy = 1; tick(); rdy = 0;
    req[12] = 1; tick();
    chk(int'(vv), 1, "R8 higher preempts"); chk(int'(vi), 12, "R8 idx");
    rdy = 1; tick(); rdy = 0;
    req[0] = 1; tick();
    chk(int'(vv), 0, "R8 equal blocked");
    ret = 1; tick(); ret = 0;
    chk(int'(vi), 0, "R9 retire top only");
    drain(); req = '0; tick();

    // R9 return with nothing in service
    ret = 1; tick(); ret = 0;
    req[4] = 1; tick();
    chk(int'(vv), 1, "R9 empty return harmless");
    // R7 back-pressure
    req[15] = 1; tick();
    for (int k = 0; k < 3; k++) begin
      tick(); chk(int'(vi), 4, "R7 held under back-pressure");
    end
    drain(); req = '0; tick();

    // R12 take and new edge in the same cycle
    req[8] = 1; tick(); req[8] = 0; tick();
    req[8] = 1; rdy = 1; tick(); rdy = 0;
    chk(int'(vv), 0, "R12 hidden at own level"); chk(int'(ie), 1, "R12 flag kept");
    ret = 1; tick(); ret = 0;
    chk(int'(vv), 1, "R12 reoffered"); chk(int'(vi), 8, "R12 idx");
    drain(); req = '0; tick();

    // R11 wake mask
    wmask[14] = 1; gen = 0; req[11] = 1; tick();
    chk(int'(sw), 0, "R11 unmasked source no wake"); chk(int'(ie), 1, "R10 idle");
    req[14] = 1; tick();
    chk(int'(sw), 1, "R11 masked source wakes");
    gen = 1; drain(); req = '0; wmask = '0; tick();

    // random overlap phase
    for (int c = 0; c < 600; c++) begin
      req   = N'($urandom) & N'($urandom);
      rdy   = ($urandom % 3) != 0;
      ret   = ($urandom % 4) == 0;
      gen   = ($urandom % 8) != 0;
      en    = N'($urandom) | N'($urandom);
      wmask = N'($urandom);
      if (($urandom % 50) == 0) prio = 12'($urandom);
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule